// File: doc/BRIEF.md
# Stepping Motor Drive Pulse Generator

This block produces the drive waveform for the bipolar stepping motor of an analog clock. A one-cycle enable arrives at 32768 Hz. Each of these ticks moves a position counter forward through one motor period. A fixed-width drive pulse starts every period, at the tick where the counter leaves position zero. During the pulse one phase output is high and the other is low. The phase that goes high swaps on every pulse. Between pulses both phases rest low.

The normal period, the test period and the pulse width are all given as tick counts at elaboration time. A qualified motor-test request selects the test period in place of the normal one. The request is sampled only at the tick that starts a pulse, so changing it part-way through a period alters nothing until the next period begins. The pulse width is the same in both modes. The period/width combination is checked at elaboration: either both periods are at least four times the width, or both are exactly twice the width.

Top module: `stepmotor_pulse_former`

## Requirements
- R1: While reset is high, and in the cycle after it, `drv_a`, `drv_b` and `pulse_act` are all 0.
- R2: The first enabled tick after reset starts a pulse. In that pulse `drv_a`=1 and `drv_b`=0.
- R3: Each pulse lasts exactly `WIDTH_TICKS` enabled ticks. `pulse_act` is 1 for exactly as long as one phase is high.
- R4: `drv_a` and `drv_b` are never both 1. Between pulses both are 0.
- R5: Successive pulses alternate: a pulse with `drv_a`=1 is followed by one with `drv_b`=1, and the other way round.
- R6: If `test_req` is 0 at the tick that starts a pulse, the next pulse starts `PERIOD_TICKS` ticks after that one.
- R7: If `test_req` is 1 at the tick that starts a pulse, the next pulse starts `TEST_TICKS` ticks later. The pulse width still equals `WIDTH_TICKS`.
- R8: Changes of `test_req` at any tick other than a pulse start do not change the length of the current period.
- R9: While `tick_en` is 0, the outputs and the period position stay unchanged.
- R10: Elaboration fails unless both periods are at least 4×`WIDTH_TICKS`, or both equal exactly 2×`WIDTH_TICKS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle 32768 Hz time-base enable |
| test_req | input | 1 | Qualified motor-test request; selects the test period |
| drv_a | output | 1 | First motor phase, high while a pulse of this polarity is active |
| drv_b | output | 1 | Second motor phase, high while a pulse of this polarity is active |
| pulse_act | output | 1 | High while any drive pulse is active |

## Verification
A vector sequence runs the period pattern through mixed runs of normal and test periods. Each vector chooses the mode for the next period. Some vectors also toggle the request in the middle of a pulse. Comparing measured period lengths then tells a correctly sampled mode apart from one picked up at the wrong tick. Alternating polarity is checked across the sequence, so a missed toggle or a double toggle shows up. A stall of the enable inside a pulse separates counting ticks from counting clocks. A reset in the middle of a gap confirms that polarity restarts on the first phase.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   // Legal period/width pairing: both periods at least four widths,
   // or both exactly two widths.
   function automatic bit ratio_ok(input int unsigned per,
                                   input int unsigned tst,
                                   input int unsigned wid);
      bit wide_gap;
      bit half_duty;
      wide_gap  = (per >= 4 * wid) && (tst >= 4 * wid);
      half_duty = (per == 2 * wid) && (tst == 2 * wid);
      return (wid >= 1) && (wide_gap || half_duty);
   endfunction

endpackage

// File: rtl/mpf_period_ctr.sv
module mpf_period_ctr #(
   parameter int unsigned PERIOD_TICKS = 65536,
   parameter int unsigned TEST_TICKS   = 8192,
   parameter int unsigned WIDTH_TICKS  = 768
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_en,
   input  logic test_req,
   output logic pulse_slot,
   output logic period_end
);

   localparam int unsigned MAX_LEN = (PERIOD_TICKS > TEST_TICKS) ? PERIOD_TICKS : TEST_TICKS;
   localparam int unsigned CW      = $clog2(MAX_LEN + 1);
   localparam logic [CW-1:0] LEN_NORM = CW'(PERIOD_TICKS);
   localparam logic [CW-1:0] LEN_TEST = CW'(TEST_TICKS);
   localparam logic [CW-1:0] LEN_WID  = CW'(WIDTH_TICKS);

   logic [CW-1:0] pos_q;
   logic [CW-1:0] len_q;
   logic [CW-1:0] len_sel;

   generate
      if (TEST_TICKS == PERIOD_TICKS) begin : g_single_len
         assign len_sel = LEN_NORM;
      end else begin : g_dual_len
         assign len_sel = test_req ? LEN_TEST : LEN_NORM;
      end
   endgenerate

   // position 0 is never the last one: every period is at least two widths
   assign period_end = (pos_q != '0) && (pos_q == len_q - 1'b1);
   assign pulse_slot = (pos_q < LEN_WID);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= '0;
         len_q <= LEN_NORM;
      end else if (tick_en) begin
         if (pos_q == '0) begin
            len_q <= len_sel;
         end
         pos_q <= period_end ? '0 : pos_q + 1'b1;
      end
   end

   assert_pos_in_range_R6 : assert property (@(posedge clk) disable iff (rst)
      pos_q < len_q);

   assert_len_choice_R7 : assert property (@(posedge clk) disable iff (rst)
      (len_q == LEN_NORM) || (len_q == LEN_TEST));

   assert_len_held_R8 : assert property (@(posedge clk) disable iff (rst)
      (tick_en && pos_q != '0) |=> $stable(len_q));

   assert_pos_stall_R9 : assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> $stable(pos_q));

endmodule

// File: rtl/mpf_phase_drive.sv
module mpf_phase_drive #(
   parameter int unsigned WIDTH_TICKS = 768
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_en,
   input  logic pulse_slot,
   input  logic period_end,
   output logic drv_a,
   output logic drv_b,
   output logic pulse_act
);
   import mpf_pkg::*;

   localparam int unsigned HW = $clog2(WIDTH_TICKS + 1);

   logic  drive_q;
   side_e phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         drive_q <= 1'b0;
         phase_q <= SIDE_A;
      end else if (tick_en) begin
         drive_q <= pulse_slot;
         if (period_end) begin
            phase_q <= (phase_q == SIDE_A) ? SIDE_B : SIDE_A;
         end
      end
   end

   assign drv_a     = drive_q && (phase_q == SIDE_A);
   assign drv_b     = drive_q && (phase_q == SIDE_B);
   assign pulse_act = drive_q;

   // checking state: ticks spent high, and polarity of the previous pulse
   logic [HW-1:0] hi_ticks_q;
   side_e         last_side_q;
   logic          seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_ticks_q  <= '0;
         last_side_q <= SIDE_A;
         seen_q      <= 1'b0;
      end else begin
         if (!drive_q) begin
            hi_ticks_q <= '0;
         end else if (tick_en) begin
            hi_ticks_q <= hi_ticks_q + 1'b1;
         end
         if (drive_q && tick_en && !pulse_slot) begin
            last_side_q <= phase_q;
            seen_q      <= 1'b1;
         end
      end
   end

   assert_one_side_R4 : assert property (@(posedge clk) disable iff (rst)
      !(drv_a && drv_b));

   assert_width_R3 : assert property (@(posedge clk) disable iff (rst)
      (drive_q && tick_en && !pulse_slot) |-> (hi_ticks_q == HW'(WIDTH_TICKS - 1)));

   assert_alternate_R5 : assert property (@(posedge clk) disable iff (rst)
      ($rose(drive_q) && seen_q) |-> (phase_q != last_side_q));

   assert_drive_stall_R9 : assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> ($stable(drv_a) && $stable(drv_b)));

endmodule

// File: rtl/stepmotor_pulse_former.sv
module stepmotor_pulse_former #(
   parameter int unsigned PERIOD_TICKS = 65536,
   parameter int unsigned TEST_TICKS   = 8192,
   parameter int unsigned WIDTH_TICKS  = 768
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_en,
   input  logic test_req,
   output logic drv_a,
   output logic drv_b,
   output logic pulse_act
);

   // R10: reject period/width pairings outside the allowed ratios
   generate
      if (!mpf_pkg::ratio_ok(PERIOD_TICKS, TEST_TICKS, WIDTH_TICKS)) begin : g_bad_ratio_R10
         $error("stepmotor_pulse_former: period/width ratio not allowed");
      end
   endgenerate

   logic pulse_slot;
   logic period_end;

   mpf_period_ctr #(
      .PERIOD_TICKS (PERIOD_TICKS),
      .TEST_TICKS   (TEST_TICKS),
      .WIDTH_TICKS  (WIDTH_TICKS)
   ) ctr_i (
      .clk        (clk),
      .rst        (rst),
      .tick_en    (tick_en),
      .test_req   (test_req),
      .pulse_slot (pulse_slot),
      .period_end (period_end)
   );

   mpf_phase_drive #(
      .WIDTH_TICKS (WIDTH_TICKS)
   ) drv_i (
      .clk        (clk),
      .rst        (rst),
      .tick_en    (tick_en),
      .pulse_slot (pulse_slot),
      .period_end (period_end),
      .drv_a      (drv_a),
      .drv_b      (drv_b),
      .pulse_act  (pulse_act)
   );

   assert_flag_match_R3 : assert property (@(posedge clk) disable iff (rst)
      pulse_act == (drv_a || drv_b));

endmodule

// File: tb/stepmotor_pulse_former_tb_top.sv
module stepmotor_pulse_former_tb_top;

   localparam int unsigned P = 16;
   localparam int unsigned T = 12;
   localparam int unsigned W = 3;

   // each vector: bit1 = toggle test_req mid-pulse, bit0 = test_req set in the gap
   localparam logic [1:0] VEC [8] = '{2'b00, 2'b01, 2'b10, 2'b11,
                                      2'b01, 2'b00, 2'b11, 2'b10};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick_en = 1'b0;
   logic test_req = 1'b0;
   logic drv_a, drv_b, pulse_act;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   stepmotor_pulse_former #(
      .PERIOD_TICKS (P),
      .TEST_TICKS   (T),
      .WIDTH_TICKS  (W)
   ) dut_i (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .test_req  (test_req),
      .drv_a     (drv_a),
      .drv_b     (drv_b),
      .pulse_act (pulse_act)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // entry: at a negedge in the first cycle of a pulse; exit: same for the next pulse
   task automatic run_period(input bit side_b, input int exp_len, input bit flip,
                             input bit next_test, input int stall);
      int  width = 0;
      int  len   = 0;
      bit  gap_bad = 0;
      bit  both_hi = 0;
      logic a0, b0;
      chk(pulse_act && drv_a == !side_b && drv_b == side_b, "R5 polarity",
          {drv_a, drv_b}, side_b ? 1 : 2);
      if (stall > 0) begin
         a0 = drv_a;
         b0 = drv_b;
         tick_en = 1'b0;
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            width++;
            len++;
            if (drv_a !== a0 || drv_b !== b0 || !pulse_act) both_hi = 1;
         end
         chk(!both_hi, "R9 stall hold", {drv_a, drv_b}, {a0, b0});
         both_hi = 0;
         tick_en = 1'b1;
      end
      while (pulse_act && len < 200) begin
         if (drv_a && drv_b) both_hi = 1;
         width++;
         len++;
         if (flip && len == 2) test_req = ~test_req;
         @(negedge clk);
      end
      while (!pulse_act && len < 200) begin
         if (drv_a || drv_b) gap_bad = 1;
         if (len == width) test_req = next_test;
         len++;
         @(negedge clk);
      end
      chk(width == W + stall, "R3 width", width, W + stall);
      chk(len == exp_len + stall, exp_len == T ? "R7 test period" : "R6 normal period",
          len, exp_len + stall);
      chk(!gap_bad && !both_hi, "R4 idle low", gap_bad, 0);
   endtask

   initial begin
      #(8 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit side;
      int exp_len;
      repeat (4) @(negedge clk);
      chk(!drv_a && !drv_b && !pulse_act, "R1 reset", {drv_a, drv_b, pulse_act}, 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      chk(!drv_a && !drv_b && !pulse_act, "R9 no tick after reset", {drv_a, drv_b, pulse_act}, 0);
      tick_en = 1'b1;
      @(negedge clk);
      chk(drv_a && !drv_b && pulse_act, "R2 first pulse", {drv_a, drv_b}, 2);

      side    = 1'b0;
      exp_len = P;
      for (int i = 0; i < 8; i++) begin
         // R8: vectors with bit1 set toggle test_req inside the pulse
         run_period(side, exp_len, VEC[i][1], VEC[i][0], 0);
         exp_len = VEC[i][0] ? T : P;
         side    = ~side;
      end

      // R9: enable held low inside a pulse stretches it by the stall
      run_period(side, exp_len, 1'b0, 1'b0, 5);
      side    = ~side;
      exp_len = P;

      // R1/R2: reset during a gap restarts on the first phase
      repeat (W + 2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(!drv_a && !drv_b && !pulse_act, "R1 mid-run reset", {drv_a, drv_b, pulse_act}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(drv_a && !drv_b && pulse_act, "R2 restart polarity", {drv_a, drv_b}, 2);
      run_period(1'b0, P, 1'b0, 1'b1, 0);
      run_period(1'b1, T, 1'b0, 1'b0, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule